// File: doc/BRIEF.md
# Byte-Programmed Three-Channel Interval Timer

This peripheral holds three independent 16-bit down-counters behind a byte-wide register port with four addresses. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is a shared control port. Software sets up a channel by writing a control byte to address 3. It then writes the initial count to that channel's data port, either as one byte or as a low byte followed by a high byte.

Each channel has a slow count clock input, a gate input and one output. The count clock is brought into the system clock domain by a synchronizer. Each rising edge of it becomes one count step. A channel counts in plain binary or in four-digit BCD. It runs either as a rate generator, which drops its output for one count step per period, or as a square-wave generator. The count is held while the channel's gate is low.

Top module: `byte_interval_timer`

## Requirements
- R1: After a synchronous reset every output is high and stays high until a count has been written and loaded into that channel. The reset configuration of every channel is word format, rate generator, binary.
- R2: The control byte at address 3 is decoded as follows. Bits [7:6] select the channel, bits [5:4] give the access format, bits [3:1] give the mode and bit 0 is the BCD flag. An accepted control byte replaces the channel's configuration, stops its counting, drives its output high and returns its byte pointer to the low byte.
- R3: In word format (format 3), the first data write is the low byte and the second is the high byte. The new count is loaded on the clock edge after the edge that samples the high-byte write. Counting with the new count starts on the edge after that.
- R4: In low-only format (format 1), each data write loads the count {0x00, byte}. In high-only format (format 2), each data write loads the count {byte, 0x00}. In both cases the load happens on the edge after the write.
- R5: A control byte is ignored, with no effect on any channel, when its channel select is 3, its format is 0, or bit 2 (mode bit 1) is 0. Only modes with mode[1:0] = 2 or 3 are accepted.
- R6: While a channel's gate is low, its count and its output hold their values.
- R7: With mode[1:0] = 2 (rate generator), the output is low for exactly one count step and high for N-1 steps in each period of N steps. The count reloads on the step after it reaches 1.
- R8: With mode[1:0] = 3 (square wave), the output is high for ceil(N/2) steps and low for floor(N/2) steps. It starts high after the count is loaded.
- R9: With the BCD flag set, each 4-bit digit borrows from 0 to 9, so a count of 0x0010 gives a period of 10 steps and a count of 0 gives 10000 steps. With the flag clear, 0x0010 gives 16 steps and 0 gives 65536 steps.
- R10: The channels count independently, each from its own count clock and gate.
- R11: Suppose a rising transition of a count clock input is first sampled high at clock edge k. It takes effect as one count step at edge k+SYNC_STAGES, provided the gate is high at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| addr | input | 2 | Register address: 0..2 channel data, 3 control |
| wdata | input | 8 | Write data byte |
| cnt_clk | input | N_CH | Per-channel count clock, asynchronous to clk |
| gate | input | N_CH | Per-channel count enable, sampled on clk |
| tmr_out | output | N_CH | Registered per-channel output |

## Verification
The bench uses the defaults N_CH = 3 and SYNC_STAGES = 2. It drives each channel's count clock at its own rate: one count step every 2, 4 and 6 system clocks. At these rates all three channels run at once with different periods. The rate is fast enough that a BCD count of 0 (10000 steps) completes a full period within the run. The high-only format with a count of 256 steps also completes. A cycle-by-cycle model of all three channels checks the two-stage synchronizer latency and the one-edge load delay on every clock. It also checks the odd-count square-wave phase split on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int DIGITS = 4;
  localparam int CNT_W  = 4 * DIGITS;

  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_LO   = 2'd1,
    FMT_HI   = 2'd2,
    FMT_WORD = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e fmt;
    logic square;
    logic bcd;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_RESET = '{fmt: FMT_WORD, square: 1'b0, bcd: 1'b0};
endpackage

// File: rtl/tmr_sync.sv
// Brings a slow count clock into the clk domain; one-cycle pulse per rising edge.
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr_dec.sv
// Decrement by one, binary or BCD (each digit borrows 0 -> 9).
module tmr_dec
  import tmr_pkg::*;
(
  input  logic [CNT_W-1:0] val,
  input  logic             bcd,
  output logic [CNT_W-1:0] res
);
  always_comb begin
    logic borrow;
    res    = val;
    borrow = 1'b1;
    if (!bcd) begin
      res = val - CNT_W'(1);
    end else begin
      for (int d = 0; d < DIGITS; d++) begin
        if (borrow) begin
          if (val[4*d +: 4] == 4'd0) begin
            res[4*d +: 4] = 4'd9;
          end else begin
            res[4*d +: 4] = val[4*d +: 4] - 4'd1;
            borrow        = 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tmr_channel.sv
// One counter channel: byte pointer, count holding register, down-counter, output.
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  chan_cfg_t         cfg_in,
  input  logic              data_we,
  input  logic [BYTE_W-1:0] data_in,
  input  logic              tick,
  input  logic              gate,
  output logic              out
);
  chan_cfg_t         cfg_q;
  logic              ptr_q;
  logic [BYTE_W-1:0] lo_q;
  logic [CNT_W-1:0]  init_q;
  logic              pend_q;
  logic              arm_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              hold_q;
  logic              out_q;

  logic [CNT_W-1:0]  minus1, minus2, reload_val, rate_nxt, new_init;
  logic              load_set, run;

  tmr_dec u_dec_a (.val(cnt_q),  .bcd(cfg_q.bcd), .res(minus1));
  tmr_dec u_dec_b (.val(minus1), .bcd(cfg_q.bcd), .res(minus2));

  // square wave counts by two from the even part of the count
  assign reload_val = cfg_q.square ? {init_q[CNT_W-1:1], 1'b0} : init_q;
  assign rate_nxt   = (cnt_q == CNT_W'(1)) ? init_q : minus1;
  assign run        = arm_q & tick & gate & ~pend_q;

  always_comb begin
    load_set = 1'b0;
    new_init = init_q;
    case (cfg_q.fmt)
      FMT_LO: begin
        load_set = data_we;
        new_init = {{BYTE_W{1'b0}}, data_in};
      end
      FMT_HI: begin
        load_set = data_we;
        new_init = {data_in, {BYTE_W{1'b0}}};
      end
      FMT_WORD: begin
        load_set = data_we & ptr_q;
        new_init = {data_in, lo_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= CFG_RESET;
      ptr_q  <= 1'b0;
      lo_q   <= '0;
      init_q <= '0;
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
      out_q  <= 1'b1;
    end else if (cfg_we) begin
      cfg_q  <= cfg_in;
      ptr_q  <= 1'b0;
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
      hold_q <= 1'b0;
      out_q  <= 1'b1;
    end else begin
      if (data_we && cfg_q.fmt == FMT_WORD) begin
        ptr_q <= ~ptr_q;
        if (!ptr_q) lo_q <= data_in;
      end
      if (load_set) init_q <= new_init;
      pend_q <= load_set;

      if (pend_q) begin
        cnt_q  <= reload_val;
        arm_q  <= 1'b1;
        hold_q <= 1'b0;
        out_q  <= cfg_q.square | (init_q != CNT_W'(1));
      end else if (run) begin
        if (cfg_q.square) begin
          if (cnt_q == CNT_W'(2)) begin
            if (out_q && init_q[0] && !hold_q) begin
              hold_q <= 1'b1;          // odd count: high phase one step longer
            end else begin
              cnt_q  <= reload_val;
              out_q  <= ~out_q;
              hold_q <= 1'b0;
            end
          end else begin
            cnt_q <= minus2;
          end
        end else begin
          cnt_q <= rate_nxt;
          out_q <= (rate_nxt != CNT_W'(1));
        end
      end
    end
  end

  assign out = out_q;
endmodule

// File: rtl/byte_interval_timer.sv
// Three-channel timer behind a byte port: addresses 0..N_CH-1 data, 3 control.
module byte_interval_timer
  import tmr_pkg::*;
#(
  parameter int N_CH        = 3,   // at most 3: the select field is 2 bits, value 3 unused
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [7:0]      wdata,
  input  logic [N_CH-1:0] cnt_clk,
  input  logic [N_CH-1:0] gate,
  output logic [N_CH-1:0] tmr_out
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic [N_CH-1:0] chan_tick;
  logic            ctrl_ok;
  chan_cfg_t       cfg_word;
  logic            unused_mode_hi;

  // accepted control byte: nonzero format and mode[1] set (modes x10 / x11)
  assign ctrl_ok  = wr_en && (addr == CTRL_ADDR) && (wdata[5:4] != 2'b00) && wdata[2];
  assign cfg_word = '{fmt: fmt_e'(wdata[5:4]), square: wdata[1], bcd: wdata[0]};
  assign unused_mode_hi = wdata[3];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic ctrl_we, data_we;
    assign ctrl_we = ctrl_ok && (wdata[7:6] == 2'(i));
    assign data_we = wr_en && (addr == 2'(i));

    tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_in(cnt_clk[i]), .rise(chan_tick[i])
    );

    tmr_channel u_chan (
      .clk(clk), .rst(rst),
      .cfg_we(ctrl_we), .cfg_in(cfg_word),
      .data_we(data_we), .data_in(wdata),
      .tick(chan_tick[i]), .gate(gate[i]),
      .out(tmr_out[i])
    );
  end
endmodule

// File: rtl/byte_interval_timer_chk.sv
module byte_interval_timer_chk #(
  parameter int N_CH = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [1:0]      addr,
  input logic [7:0]      wdata,
  input logic [N_CH-1:0] gate,
  input logic [N_CH-1:0] tick,
  input logic [N_CH-1:0] tmr_out
);
  logic rst_q;
  logic unused_bits;
  assign unused_bits = ^{wdata[3], wdata[1:0]};

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      AST_RESET_OUT_HIGH: assert (tmr_out == {N_CH{1'b1}}); // R1
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ast
    AST_CTRL_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == 2'd3 && wdata[7:6] == 2'(i) && wdata[5:4] != 2'b00 && wdata[2])
      |=> tmr_out[i]); // R2

    AST_IGNORED_CTRL: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == 2'd3 && (wdata[7:6] == 2'd3 || wdata[5:4] == 2'b00 || !wdata[2])
       && !tick[i] && !$past(wr_en))
      |=> $stable(tmr_out[i])); // R5

    AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (!gate[i] && !wr_en && !$past(wr_en)) |=> $stable(tmr_out[i])); // R6

    AST_OUT_ON_STEP: assert property (@(posedge clk) disable iff (rst)
      (!tick[i] && !wr_en && !$past(wr_en)) |=> $stable(tmr_out[i])); // R11
  end
endmodule

bind byte_interval_timer byte_interval_timer_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .gate(gate), .tick(chan_tick), .tmr_out(tmr_out)
);

// File: tb/byte_interval_timer_tb.sv
module byte_interval_timer_tb;
  localparam int NC   = 3;
  localparam int SS   = 2;
  localparam int LIM  = 50000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [NC-1:0] cnt_clk = '0;
  logic [NC-1:0] gate = '1;
  logic [NC-1:0] tmr_out;

  int    checks = 0;
  int    errors = 0;
  bit    model_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  byte_interval_timer #(.N_CH(NC), .SYNC_STAGES(SS)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt_clk(cnt_clk), .gate(gate), .tmr_out(tmr_out)
  );

  always #10 clk = ~clk;

  // count clocks: channel c toggles every c+1 system clocks
  int div_cnt [NC];
  always @(negedge clk) begin
    for (int c = 0; c < NC; c++) begin
      div_cnt[c] = div_cnt[c] + 1;
      if (div_cnt[c] >= c + 1) begin
        div_cnt[c] = 0;
        cnt_clk[c] = ~cnt_clk[c];
      end
    end
  end

  // ---------------- behavioural reference model ----------------
  int         m_fmt [NC], m_lo [NC], m_init [NC], m_cnt [NC];
  bit         m_sq [NC], m_bcd [NC], m_ptr [NC], m_pend [NC], m_arm [NC], m_hold [NC];
  bit         m_out [NC];
  bit [SS:0]  m_hist [NC];

  function automatic int raw2val(int raw, bit bcd);
    if (!bcd) return raw;
    return ((raw >> 12) & 15) * 1000 + ((raw >> 8) & 15) * 100 + ((raw >> 4) & 15) * 10 + (raw & 15);
  endfunction

  function automatic int step_down(int v, bit bcd);
    if (v == 0) return bcd ? 9999 : 65535;
    return v - 1;
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < NC; c++) begin
      bit tk, ctl, dat, ld;
      int ni, iv, nx;
      tk = m_hist[c][SS-1] & ~m_hist[c][SS];
      if (rst) begin
        m_hist[c] = '0;
        m_fmt[c] = 3; m_sq[c] = 0; m_bcd[c] = 0; m_ptr[c] = 0; m_lo[c] = 0;
        m_init[c] = 0; m_pend[c] = 0; m_arm[c] = 0; m_cnt[c] = 0; m_hold[c] = 0; m_out[c] = 1;
      end else begin
        m_hist[c] = {m_hist[c][SS-1:0], cnt_clk[c]};
        ctl = wr_en && addr == 2'd3 && wdata[7:6] == 2'(c) && wdata[5:4] != 0 && wdata[2];
        dat = wr_en && addr == 2'(c);
        if (ctl) begin
          m_fmt[c] = int'(wdata[5:4]); m_sq[c] = wdata[1]; m_bcd[c] = wdata[0];
          m_ptr[c] = 0; m_pend[c] = 0; m_arm[c] = 0; m_hold[c] = 0; m_out[c] = 1;
        end else begin
          iv = raw2val(m_init[c], m_bcd[c]);
          if (m_pend[c]) begin
            m_cnt[c] = m_sq[c] ? iv - (iv % 2) : iv;
            m_arm[c] = 1; m_hold[c] = 0;
            m_out[c] = m_sq[c] || (iv != 1);
          end else if (m_arm[c] && tk && gate[c]) begin
            if (m_sq[c]) begin
              if (m_cnt[c] == 2) begin
                if (m_out[c] && (iv % 2 == 1) && !m_hold[c]) m_hold[c] = 1;
                else begin
                  m_cnt[c] = iv - (iv % 2); m_out[c] = !m_out[c]; m_hold[c] = 0;
                end
              end else begin
                m_cnt[c] = step_down(step_down(m_cnt[c], m_bcd[c]), m_bcd[c]);
              end
            end else begin
              nx = (m_cnt[c] == 1) ? iv : step_down(m_cnt[c], m_bcd[c]);
              m_cnt[c] = nx;
              m_out[c] = (nx != 1);
            end
          end
          ld = 0; ni = m_init[c];
          if (dat) begin
            case (m_fmt[c])
              1: begin ld = 1; ni = int'(wdata); end
              2: begin ld = 1; ni = int'(wdata) * 256; end
              3: begin
                if (m_ptr[c]) begin ld = 1; ni = int'(wdata) * 256 + m_lo[c]; end
                else m_lo[c] = int'(wdata);
                m_ptr[c] = !m_ptr[c];
              end
              default: ;
            endcase
          end
          m_pend[c] = ld;
          if (ld) m_init[c] = ni;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      for (int c = 0; c < NC; c++) begin
        checks++;
        if (tmr_out[c] !== m_out[c]) begin
          errors++;
          $display("FAIL %s model ch%0d: out=%0b expected=%0b at %0t", cur_req, c, tmr_out[c], m_out[c], $time);
        end
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // measure one low phase and the full period (in system clocks) of a channel output
  task automatic measure(input int ch, output int low_len, output int period);
    int n, hi;
    n = 0;
    while (tmr_out[ch] !== 1'b1 && n < LIM) begin @(negedge clk); n++; end
    n = 0;
    while (tmr_out[ch] !== 1'b0 && n < LIM) begin @(negedge clk); n++; end
    low_len = 0;
    while (tmr_out[ch] === 1'b0 && low_len < LIM) begin @(negedge clk); low_len++; end
    hi = 0;
    while (tmr_out[ch] === 1'b1 && hi < LIM) begin @(negedge clk); hi++; end
    period = low_len + hi;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int lo, per, snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_on = 1'b1;
    chk("R1 reset outputs", int'(tmr_out), 7);
    repeat (24) @(negedge clk);
    chk("R1 idle without count", int'(tmr_out), 7);

    // rate generator, word format, channel 1 (step every 4 clocks)
    cur_req = "R3/R7/R11";
    wr(2'd3, 8'h74); wr(2'd1, 8'h03); wr(2'd1, 8'h00);
    measure(1, lo, per);
    chk("R7 rate low length", lo, 4);
    chk("R7 rate period N=3", per, 12);

    // square wave channel 0 (step every 2 clocks)
    cur_req = "R8";
    wr(2'd3, 8'h36); wr(2'd0, 8'h04); wr(2'd0, 8'h00);
    measure(0, lo, per);
    chk("R8 square low N=4", lo, 4);
    chk("R8 square period N=4", per, 8);
    wr(2'd0, 8'h05); wr(2'd0, 8'h00);
    measure(0, lo, per);
    chk("R8 square low N=5", lo, 4);
    chk("R8 square period N=5", per, 10);

    // BCD on channel 2 (step every 6 clocks), then BCD zero and binary on channel 0
    cur_req = "R9/R10";
    wr(2'd3, 8'hB5); wr(2'd2, 8'h10); wr(2'd2, 8'h00);
    measure(2, lo, per);
    chk("R9 BCD 0x0010 period", per, 60);
    wr(2'd3, 8'h34); wr(2'd0, 8'h10); wr(2'd0, 8'h00);
    measure(0, lo, per);
    chk("R9 binary 0x0010 period", per, 32);
    wr(2'd3, 8'h35); wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    measure(0, lo, per);
    chk("R9 BCD zero period", per, 20000);

    // single-byte formats on channel 1
    cur_req = "R4";
    wr(2'd3, 8'h54); wr(2'd1, 8'h05);
    measure(1, lo, per);
    chk("R4 low-only period", per, 20);
    wr(2'd3, 8'h64); wr(2'd1, 8'h01);
    measure(1, lo, per);
    chk("R4 high-only period", per, 1024);

    // ignored control bytes: channel 1 must stay in low-only format
    cur_req = "R5";
    wr(2'd3, 8'h54); wr(2'd1, 8'h05);
    wr(2'd3, 8'hF4); wr(2'd3, 8'h44); wr(2'd3, 8'h70); wr(2'd3, 8'h78);
    wr(2'd1, 8'h07);
    measure(1, lo, per);
    chk("R5 ignored control, period from single byte", per, 28);

    // gate freezes channel 1
    cur_req = "R6";
    gate[1] = 1'b0;
    @(negedge clk);
    snap = int'(tmr_out[1]);
    repeat (50) @(negedge clk);
    chk("R6 output held while gate low", int'(tmr_out[1]), snap);
    gate[1] = 1'b1;

    // control write resets the byte pointer and stops the channel
    cur_req = "R2/R3";
    wr(2'd3, 8'h34); wr(2'd0, 8'h99);
    wr(2'd3, 8'h34);
    repeat (6) @(negedge clk);
    chk("R2 stopped channel output high", int'(tmr_out[0]), 1);
    wr(2'd0, 8'h06); wr(2'd0, 8'h00);
    measure(0, lo, per);
    chk("R3 pointer restarted at low byte", per, 12);

    // all channels still independent
    cur_req = "R10";
    measure(2, lo, per);
    chk("R10 channel 2 unaffected", per, 60);
    measure(1, lo, per);
    chk("R10 channel 1 unaffected", per, 28);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule